// File: doc/BRIEF.md
# Downstream Port Power Controller

This block switches supply power for a set of downstream hub ports (four by default). Each port has an active-low enable output that drives an external power switch, and an active-low overcurrent input from that switch. Each overcurrent input passes through a two-flop synchroniser and a consecutive-cycle glitch filter before it counts as a fault. Single-cycle per-port strobes from the hub's request decoder turn ports on or off. A per-port overcurrent status and a sticky change flag feed the hub's port status register.

A static mode input selects between two policies. In per-port mode each port follows only its own strobes and its own fault, so a fault removes power from that port alone. In ganged mode any strobe acts on every port, the filtered faults are ORed into one group fault, and that fault cuts power to all ports and shows on every status bit. A port that a fault turned off stays off until a power-on strobe arrives after the fault has cleared.

Top module: `port_power_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, every enable output is 1 (all ports off) and every status and change bit is 0. Bit i of every vector belongs to port i.
- R2: In per-port mode (`gang_mode`=0) a 1 on `on_req[i]` drives `pwr_en_n[i]` to 0, and a 1 on `off_req[i]` drives it to 1. The change shows on the clock edge that samples the strobe. The off strobe wins when both hit the same port in the same cycle.
- R3: In ganged mode (`gang_mode`=1) a strobe on any bit of `on_req` or `off_req` acts on all ports at once, so the enable outputs are always all 0 or all 1.
- R4: A port's fault is accepted only when its synchronised overcurrent input has been 0 for `FILT_LEN` consecutive clocks. A low pulse lasting `FILT_LEN`-1 clocks leaves the status at 0. With a steady low input, status rises `FILT_LEN`+2 clocks after the input falls, and it returns to 0 three clocks after the input goes high.
- R5: In ganged mode a filtered fault on any input sets every status bit, and one clock later every enable output is 1.
- R6: In per-port mode a filtered fault on port i sets only `oc_status[i]`, and one clock later only port i is powered off. The other ports keep their state.
- R7: A port is never powered on while its (group) fault is present, so an on strobe during a fault is ignored. After the fault clears the port stays off until a new on strobe arrives.
- R8: `oc_change[i]` becomes 1 one clock after `oc_status[i]` changes in either direction, and it stays 1 until it is acknowledged.
- R9: A 1 on `chg_ack[i]` clears `oc_change[i]` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gang_mode | input | 1 | 1 selects ganged policy, 0 selects per-port; static while running |
| on_req | input | NPORTS | Power-on strobes, one per port |
| off_req | input | NPORTS | Power-off strobes, one per port |
| oc_n | input | NPORTS | Overcurrent inputs from the switches, 0 = fault, asynchronous |
| chg_ack | input | NPORTS | Acknowledge strobes that clear the change flags |
| pwr_en_n | output | NPORTS | Power enables, 0 = port powered |
| oc_status | output | NPORTS | Filtered overcurrent status, 1 = fault |
| oc_change | output | NPORTS | Sticky flag: status changed since the last acknowledge |

## Verification
The controller is tested with mixed on patterns (alternate ports, then the rest), an off strobe on one port, and on and off strobes that collide on the same port. Together these separate correct per-port selection and priority from a shared or swapped command path. Overcurrent stimulus includes a low pulse one clock too short, which must be rejected, and a steady fault, whose status, power and change timing are checked cycle by cycle. These cases pin down the filter length and the two-stage synchroniser latency. Each fault case also tries an on strobe while the fault is present and after it clears, which tests the rule that a faulted port stays off. The same sequence is repeated in ganged mode, where a strobe or fault on a single port must move every port.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

    typedef enum logic [0:0] {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic turn_on;
        logic turn_off;
    } port_cmd_t;

    // Fault has highest priority, then off, then on.
    function automatic pwr_state_e next_pwr_state(pwr_state_e cur,
                                                   logic fault,
                                                   port_cmd_t cmd);
        pwr_state_e nxt;
        if (fault)             nxt = PWR_OFF;
        else if (cmd.turn_off) nxt = PWR_OFF;
        else if (cmd.turn_on)  nxt = PWR_ON;
        else                   nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/hpp_oc_filter.sv
module hpp_oc_filter #(
    parameter int FILT_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_n_async,
    output logic fault
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          sync1_q, sync2_q;
    logic [CW-1:0] run_q;
    logic          fault_q;

    // Two-flop synchroniser, reset to the idle (no fault) level.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= oc_n_async;
            sync2_q <= sync1_q;
        end
    end

    // Consecutive-low run counter, saturating at FILT_LEN-1.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            fault_q <= 1'b0;
        end else if (sync2_q) begin
            run_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (run_q != LAST) run_q <= run_q + 1'b1;
            fault_q <= (run_q == LAST);
        end
    end

    assign fault = fault_q;

endmodule

// File: rtl/hpp_power_core.sv
module hpp_power_core
    import hpp_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gang_mode,
    input  logic [NPORTS-1:0] on_req,
    input  logic [NPORTS-1:0] off_req,
    input  logic [NPORTS-1:0] fault,
    output logic [NPORTS-1:0] pwr_en_n,
    output logic [NPORTS-1:0] eff_fault
);
    logic group_fault, group_on, group_off;

    assign group_fault = |fault;
    assign group_on    = |on_req;
    assign group_off   = |off_req;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pwr_state_e state_q;
        port_cmd_t  cmd;
        logic       flt;

        always_comb begin
            if (gang_mode) begin
                flt          = group_fault;
                cmd.turn_on  = group_on;
                cmd.turn_off = group_off;
            end else begin
                flt          = fault[p];
                cmd.turn_on  = on_req[p];
                cmd.turn_off = off_req[p];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) state_q <= PWR_OFF;
            else     state_q <= next_pwr_state(state_q, flt, cmd);
        end

        assign pwr_en_n[p]  = (state_q != PWR_ON);
        assign eff_fault[p] = flt;
    end

endmodule

// File: rtl/hpp_change_tracker.sv
module hpp_change_tracker #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] status,
    input  logic [NPORTS-1:0] ack,
    output logic [NPORTS-1:0] changed
);
    logic [NPORTS-1:0] status_q;
    logic [NPORTS-1:0] changed_q;

    // A new edge on status takes priority over an acknowledge.
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= '0;
            changed_q <= '0;
        end else begin
            status_q  <= status;
            changed_q <= (changed_q & ~ack) | (status ^ status_q);
        end
    end

    assign changed = changed_q;

endmodule

// File: rtl/port_power_ctrl.sv
module port_power_ctrl #(
    parameter int NPORTS   = 4,
    parameter int FILT_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gang_mode,
    input  logic [NPORTS-1:0] on_req,
    input  logic [NPORTS-1:0] off_req,
    input  logic [NPORTS-1:0] oc_n,
    input  logic [NPORTS-1:0] chg_ack,
    output logic [NPORTS-1:0] pwr_en_n,
    output logic [NPORTS-1:0] oc_status,
    output logic [NPORTS-1:0] oc_change
);
    logic [NPORTS-1:0] filt_fault;

    for (genvar p = 0; p < NPORTS; p++) begin : g_filt
        hpp_oc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk        (clk),
            .rst        (rst),
            .oc_n_async (oc_n[p]),
            .fault      (filt_fault[p])
        );
    end

    hpp_power_core #(.NPORTS(NPORTS)) u_core (
        .clk       (clk),
        .rst       (rst),
        .gang_mode (gang_mode),
        .on_req    (on_req),
        .off_req   (off_req),
        .fault     (filt_fault),
        .pwr_en_n  (pwr_en_n),
        .eff_fault (oc_status)
    );

    hpp_change_tracker #(.NPORTS(NPORTS)) u_chg (
        .clk     (clk),
        .rst     (rst),
        .status  (oc_status),
        .ack     (chg_ack),
        .changed (oc_change)
    );

endmodule

// File: rtl/port_power_ctrl_chk.sv
module port_power_ctrl_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              gang_mode,
    input logic [NPORTS-1:0] on_req,
    input logic [NPORTS-1:0] pwr_en_n,
    input logic [NPORTS-1:0] oc_status,
    input logic [NPORTS-1:0] oc_change
);
    // R3: ganged outputs move together
    a_r3_ganged_uniform: assert property (@(posedge clk) disable iff (rst)
        gang_mode |-> ((pwr_en_n == '0) || (&pwr_en_n)));

    // R5: any ganged fault removes all power on the next clock
    a_r5_ganged_trip: assert property (@(posedge clk) disable iff (rst)
        (gang_mode && (|oc_status)) |=> (&pwr_en_n));

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        // R6: a port's own fault powers it off next clock
        a_r6_port_trip: assert property (@(posedge clk) disable iff (rst)
            oc_status[p] |=> pwr_en_n[p]);

        // R7: power comes on only by a request and never during a fault
        a_r7_on_needs_request: assert property (@(posedge clk) disable iff (rst)
            $fell(pwr_en_n[p]) |->
                ($past(gang_mode ? (|on_req) : on_req[p]) && !$past(oc_status[p])));

        // R8: a status edge raises the change flag one clock later
        a_r8_change_flag: assert property (@(posedge clk) disable iff (rst)
            (oc_status[p] != $past(oc_status[p])) |=> oc_change[p]);
    end

endmodule

bind port_power_ctrl port_power_ctrl_chk #(.NPORTS(NPORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gang_mode (gang_mode),
    .on_req    (on_req),
    .pwr_en_n  (pwr_en_n),
    .oc_status (oc_status),
    .oc_change (oc_change)
);

// File: tb/test_port_power_ctrl.sv
module test_port_power_ctrl;
    localparam int N = 4;
    localparam int L = 16;

    typedef struct {
        int         cyc;
        logic [3:0] pw;
        logic [3:0] st;
        logic [3:0] ch;
        string      tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         gang_mode = 1'b0;
    logic [N-1:0] on_req = '0, off_req = '0, oc_n = '1, chg_ack = '0;
    logic [N-1:0] pwr_en_n, oc_status, oc_change;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    port_power_ctrl #(.NPORTS(N), .FILT_LEN(L)) i_port_power_ctrl (
        .clk(clk), .rst(rst), .gang_mode(gang_mode),
        .on_req(on_req), .off_req(off_req), .oc_n(oc_n), .chg_ack(chg_ack),
        .pwr_en_n(pwr_en_n), .oc_status(oc_status), .oc_change(oc_change));

    task automatic expect_at(int d, logic [3:0] pw, logic [3:0] st,
                             logic [3:0] ch, string tag);
        exp_t e;
        e.cyc = cyc + d; e.pw = pw; e.st = st; e.ch = ch; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares expected items on the negedge they fall due.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (e.cyc != cyc || pwr_en_n !== e.pw || oc_status !== e.st ||
                    oc_change !== e.ch) begin
                    n_fail++;
                    $display("FAIL %s cyc=%0d: actual pwr=%b st=%b ch=%b expected pwr=%b st=%b ch=%b",
                             e.tag, cyc, pwr_en_n, oc_status, oc_change, e.pw, e.st, e.ch);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic g);
        rst = 1'b1; gang_mode = g;
        tick(3);
        rst = 1'b0;
        expect_at(1, 4'hF, 4'h0, 4'h0, "R1 reset state");
        tick(2);
    endtask

    task automatic pulse(logic [3:0] on, logic [3:0] off, logic [3:0] ack,
                         logic [3:0] pw, logic [3:0] st, logic [3:0] ch, string tag);
        on_req = on; off_req = off; chg_ack = ack;
        expect_at(1, pw, st, ch, tag);
        tick(1);
        on_req = '0; off_req = '0; chg_ack = '0;
        tick(1);
    endtask

    initial begin
        tick(1);
        // ---------------- per-port mode ----------------
        do_reset(1'b0);
        pulse(4'b0101, 4'b0000, 4'b0000, 4'b1010, 4'h0, 4'h0, "R2 on alternate ports");
        pulse(4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'h0, 4'h0, "R2 on remaining ports");
        pulse(4'b0000, 4'b0001, 4'b0000, 4'b0001, 4'h0, 4'h0, "R2 off port0");
        pulse(4'b0010, 4'b0010, 4'b0000, 4'b0011, 4'h0, 4'h0, "R2 off wins collision");
        pulse(4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'h0, 4'h0, "R2 re-on ports0-1");

        // R4: pulse one clock too short is rejected
        oc_n = 4'b1011;
        tick(L - 1);
        oc_n = 4'hF;
        for (int d = 1; d <= 6; d++) expect_at(d, 4'h0, 4'h0, 4'h0, "R4 short pulse ignored");
        tick(8);

        // R4/R6/R8: steady fault on port2
        oc_n = 4'b1011;
        for (int d = 1; d <= L + 1; d++) expect_at(d, 4'h0, 4'h0, 4'h0, "R4 filter delay");
        expect_at(L + 2, 4'b0000, 4'b0100, 4'b0000, "R4 status rises");
        expect_at(L + 3, 4'b0100, 4'b0100, 4'b0100, "R6 only port2 off, R8 flag");
        tick(L + 3);
        pulse(4'b0100, 4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0100, "R7 on ignored in fault");
        pulse(4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0100, 4'b0000, "R9 ack clears flag");

        // Release fault
        oc_n = 4'hF;
        expect_at(2, 4'b0100, 4'b0100, 4'b0000, "R4 release latency");
        expect_at(3, 4'b0100, 4'b0000, 4'b0000, "R4 status falls");
        expect_at(4, 4'b0100, 4'b0000, 4'b0100, "R8 flag on fall");
        expect_at(6, 4'b0100, 4'b0000, 4'b0100, "R7 stays off after clear");
        tick(6);
        pulse(4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 4'b0000, "R9 ack after fall");
        pulse(4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R7 on after clear");

        // ---------------- ganged mode ----------------
        do_reset(1'b1);
        pulse(4'b0001, 4'b0000, 4'b0000, 4'h0, 4'h0, 4'h0, "R3 one on strobe powers all");
        pulse(4'b0000, 4'b0100, 4'b0000, 4'hF, 4'h0, 4'h0, "R3 one off strobe cuts all");
        pulse(4'b1000, 4'b0000, 4'b0000, 4'h0, 4'h0, 4'h0, "R3 on again");

        oc_n = 4'b0111;
        expect_at(L + 1, 4'h0, 4'h0, 4'h0, "R4 ganged filter delay");
        expect_at(L + 2, 4'h0, 4'hF, 4'h0, "R5 group status");
        expect_at(L + 3, 4'hF, 4'hF, 4'hF, "R5 all ports off");
        tick(L + 3);
        pulse(4'b0001, 4'b0000, 4'b0000, 4'hF, 4'hF, 4'hF, "R7 ganged on ignored in fault");
        oc_n = 4'hF;
        expect_at(3, 4'hF, 4'h0, 4'hF, "R4 ganged status falls");
        expect_at(4, 4'hF, 4'h0, 4'hF, "R7 ganged stays off");
        tick(4);
        pulse(4'b0000, 4'b0000, 4'hF, 4'hF, 4'h0, 4'h0, "R9 ganged ack");
        pulse(4'b0010, 4'b0000, 4'b0000, 4'h0, 4'h0, 4'h0, "R7 ganged on after clear");

        tick(3);
        done = 1;
    end

    initial begin
        int waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        if (q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule